// File: doc/BRIEF.md
# Serial Converter Read Sequencer

This block is the host side of a three-wire link to a delta-sigma style converter that is driven by the host's clock. On a request it pulls chip select low while holding the serial clock low, which makes the converter accept an external serial clock. It then watches the converter's data line, which reads high while a conversion is still running and low once a result is ready.

When the line reads low, the sequencer issues a fixed number of serial clock pulses from a programmable divider of the system clock. It captures one bit on each rising edge and shifts it in, most significant bit first. It then releases chip select and presents the captured word with a one-cycle valid strobe.

If the data line stays high for a configurable number of system clock cycles, the sequencer gives up. It releases chip select and pulses an error flag. A continuous request starts a new read straight after each one ends. A single start pulse gives exactly one read.

Top module: `adc_read_seq`

## Requirements
- R1: During and right after reset, cs_n is 1, sclk is 0, result_vld is 0, timeout_err is 0 and result is all zeros.
- R2: When start or cont is high in a cycle where cs_n is high, cs_n is 0 from the next cycle. sclk is 0 in every cycle where cs_n is 1, and in the first cycle where cs_n is 0.
- R3: While cs_n is 0 and sdo_in is sampled high, sclk stays 0. At the first rising system clock edge where sdo_in is sampled low, clocking begins, and sclk first goes high HALF_DIV cycles later.
- R4: sclk spends exactly HALF_DIV system clock cycles high and HALF_DIV low per period. Exactly NBITS rising sclk edges occur between cs_n falling and the valid strobe.
- R5: sdo_in is captured at each system clock edge where sclk goes from 0 to 1. The first captured bit ends up in result[NBITS-1], so the low end-of-conversion level lands in the MSB and the last captured bit in result[0].
- R6: HALF_DIV cycles after the last rising sclk edge, sclk returns to 0. In the same cycle cs_n returns to 1 and result_vld is 1 for exactly one cycle, with the new word on result.
- R7: If sdo_in is sampled high on POLL_LIMIT consecutive polling edges, cs_n returns to 1 and timeout_err is 1 for exactly one cycle, with no sclk pulses and no result_vld. A low sample on polling edge number POLL_LIMIT-1 (counting from 0) still starts a read.
- R8: While cont is held high, a new read starts in the cycle after each completion, so cs_n is high for exactly one cycle between reads. A single start pulse with cont low gives exactly one read, and cs_n then stays high.
- R9: start and cont have no effect while cs_n is 0. A start pulse during a read changes neither the sclk sequence nor the number of words delivered.
- R10: result holds its value in every cycle where result_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a single read |
| cont | input | 1 | Level request for back-to-back reads |
| sdo_in | input | 1 | Serial data and end-of-conversion level from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles low |
| result | output | NBITS | Last captured word, MSB first on the wire |
| result_vld | output | 1 | One-cycle strobe marking a new word on result |
| timeout_err | output | 1 | One-cycle strobe marking an abandoned poll |

## Verification
The bench targets the poll-limit boundary: a converter that becomes ready on the very last permitted poll sample, and one that becomes ready one sample too late. An off-by-one limit would turn the first case into a spurious error, or would let the second case read. Start pulses arrive in the middle of a read, where a sequencer that re-armed would restart the clock train or deliver an extra word. Continuous mode is checked to leave exactly one idle cycle between reads; a slow return would stretch that gap. A divider or bit counter that is off by one shows up as the wrong number of rising edges, or as a word shifted by one bit.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_st_e;

    // serial clock edge strobes, valid for the coming system clock edge
    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen
    import adcrd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output logic      sclk,
    output sclk_evt_t evt
);
    localparam int CW = cw(HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic tick;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || !run || cnt == LAST) cnt <= '0;
                else                            cnt <= cnt + 1'b1;
            end
            assign tick = run && (cnt == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) sclk <= 1'b0;
        else if (tick)   sclk <= ~sclk;
    end

    assign evt.rise = tick && !sclk;
    assign evt.fall = tick &&  sclk;
endmodule

// File: rtl/adcrd_poll_timer.sv
module adcrd_poll_timer
    import adcrd_pkg::*;
#(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam int CW = cw(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active)    cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign expired = active && (cnt == LAST);
endmodule

// File: rtl/adcrd_rx_shift.sv
module adcrd_rx_shift
    import adcrd_pkg::*;
#(
    parameter int NBITS = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             din,
    output logic [NBITS-1:0] word,
    output logic             full
);
    localparam int CW = cw(NBITS + 1);
    localparam logic [CW-1:0] NB = CW'(NBITS);

    logic [CW-1:0] nbit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
            nbit <= '0;
        end else if (shift_en) begin
            word <= {word[NBITS-2:0], din};
            nbit <= nbit + 1'b1;
        end
    end

    assign full = (nbit == NB);
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
    import adcrd_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int POLL_LIMIT = 4096,
    parameter int NBITS      = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cont,
    input  logic             sdo_in,
    output logic             cs_n,
    output logic             sclk,
    output logic [NBITS-1:0] result,
    output logic             result_vld,
    output logic             timeout_err
);
    seq_st_e          st;
    sclk_evt_t        evt;
    logic             poll_to;
    logic             full;
    logic [NBITS-1:0] word;

    adcrd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk  (clk),
        .rst  (rst),
        .run  (st == ST_SHIFT),
        .sclk (sclk),
        .evt  (evt)
    );

    adcrd_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .active  (st == ST_POLL),
        .expired (poll_to)
    );

    adcrd_rx_shift #(.NBITS(NBITS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (st != ST_SHIFT),
        .shift_en (evt.rise),
        .din      (sdo_in),
        .word     (word),
        .full     (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            result      <= '0;
            result_vld  <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            result_vld  <= 1'b0;
            timeout_err <= 1'b0;
            unique case (st)
                ST_IDLE: if (start || cont) st <= ST_POLL;
                ST_POLL: begin
                    if (!sdo_in) begin
                        st <= ST_SHIFT;
                    end else if (poll_to) begin
                        st          <= ST_IDLE;
                        timeout_err <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (evt.fall && full) begin
                        st         <= ST_IDLE;
                        result     <= word;
                        result_vld <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cs_n = (st == ST_IDLE);
endmodule

// File: rtl/adcrd_chk.sv
module adcrd_chk #(
    parameter int NBITS = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             sclk,
    input logic [NBITS-1:0] result,
    input logic             result_vld,
    input logic             timeout_err
);
    logic       sclk_d;
    logic [7:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            rises  <= '0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)                rises <= '0;
            else if (sclk && !sclk_d) rises <= rises + 1'b1;
        end
    end

    // R2
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R2
    select_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> !sclk);

    // R4
    edge_total_chk: assert property (@(posedge clk) disable iff (rst)
        result_vld |-> (rises == 8'(NBITS)));

    // R6
    vld_release_chk: assert property (@(posedge clk) disable iff (rst)
        result_vld |-> $rose(cs_n));

    // R6
    vld_single_chk: assert property (@(posedge clk) disable iff (rst)
        result_vld |=> !result_vld);

    // R7
    err_release_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> ($rose(cs_n) && !result_vld && rises == 8'd0));

    // R7
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> !timeout_err);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !result_vld |-> $stable(result));
endmodule

bind adc_read_seq adcrd_chk #(.NBITS(NBITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .result      (result),
    .result_vld  (result_vld),
    .timeout_err (timeout_err)
);

// File: tb/sim_adc_read_seq.sv
module sim_adc_read_seq;
    localparam int DIV = 3;
    localparam int LIM = 20;
    localparam int NB  = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cont = 1'b0;
    logic          sdo = 1'b1;
    logic          cs_n, sclk, result_vld, timeout_err;
    logic [NB-1:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    adc_read_seq #(.HALF_DIV(DIV), .POLL_LIMIT(LIM), .NBITS(NB)) u0 (
        .clk(clk), .rst(rst), .start(start), .cont(cont), .sdo_in(sdo),
        .cs_n(cs_n), .sclk(sclk), .result(result),
        .result_vld(result_vld), .timeout_err(timeout_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    // reference model: 0 idle, 1 polling, 2 clocking
    int            m_mode = 0;
    int            m_cnt  = 0;
    int            m_k    = 0;
    logic [NB-1:0] m_acc  = '0;
    logic [NB-1:0] m_res  = '0;
    bit            m_vld  = 0;
    bit            m_err  = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_mode = 0; m_res = '0; m_vld = 0; m_err = 0;
        end else begin
            m_vld = 0;
            m_err = 0;
            case (m_mode)
                0: if (start || cont) begin m_mode = 1; m_cnt = 0; end
                1: begin
                    if (!sdo) begin m_mode = 2; m_k = 0; m_acc = '0; end
                    else if (m_cnt == LIM - 1) begin m_mode = 0; m_err = 1; end
                    else m_cnt++;
                end
                default: begin
                    m_k++;
                    if (m_k % (2 * DIV) == DIV) m_acc = {m_acc[NB-2:0], sdo};
                    if (m_k == 2 * DIV * NB) begin m_mode = 0; m_vld = 1; m_res = m_acc; end
                end
            endcase
        end
    end

    // converter model and output comparison
    logic [NB-1:0] cv_word = '0;
    int            cv_busy = 0;
    int            busy_left = 0;
    int            idx = 0;
    logic          prev_sclk = 1'b0;
    int            vld_cnt = 0;
    int            err_cnt = 0;
    int            rise_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(cs_n === (m_mode == 0), "R2 cs_n", 32'(cs_n), 32'(m_mode == 0));
            chk(sclk === (m_mode == 2 && ((m_k / DIV) % 2) == 1), "R4 sclk",
                32'(sclk), 32'(m_mode == 2 && ((m_k / DIV) % 2) == 1));
            chk(result_vld === m_vld, "R6 result_vld", 32'(result_vld), 32'(m_vld));
            chk(timeout_err === m_err, "R7 timeout_err", 32'(timeout_err), 32'(m_err));
            chk(result === m_res, "R5 result", 32'(result), 32'(m_res));
            if (!cs_n && sclk && !prev_sclk) rise_cnt++;
            if (result_vld) begin
                vld_cnt++;
                chk(rise_cnt == NB, "R4 rise count", rise_cnt, NB);
                chk(result === cv_word, "R5 word", 32'(result), 32'(cv_word));
            end
            if (timeout_err) err_cnt++;
            if (cs_n) rise_cnt = 0;
        end
        if (cs_n) begin
            idx = 0; busy_left = cv_busy; sdo = 1'b1;
        end else if (busy_left > 0) begin
            busy_left--; sdo = 1'b1;
        end else begin
            if (prev_sclk && !sclk) idx++;
            sdo = (idx < NB) ? cv_word[NB-1-idx] : 1'b1;
        end
        prev_sclk = sclk;
    end

    task automatic run_read(input logic [NB-1:0] w, input int busy, output int nv, output int ne);
        int v0 = vld_cnt;
        int e0 = err_cnt;
        cv_word = w;
        cv_busy = busy;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            if (vld_cnt != v0 || err_cnt != e0) break;
        end
        repeat (4) @(posedge clk);
        nv = vld_cnt - v0;
        ne = err_cnt - e0;
    endtask

    initial begin : watchdog
        wait (cycles > 20000);
        fails++;
        checks++;
        $display("FAIL watchdog act=%0d exp=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int nv, ne, v0;
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs during reset
        chk(cs_n === 1'b1 && sclk === 1'b0 && result_vld === 1'b0 && timeout_err === 1'b0 && result === '0,
            "R1 reset", {cs_n, sclk, result_vld, timeout_err}, 32'h8);
        rst = 1'b0;
        repeat (5) @(posedge clk);
        #2;
        chk(cs_n === 1'b1 && sclk === 1'b0, "R1 after reset", {cs_n, sclk}, 32'h2);

        // R3: ready at once, ready after a delay
        run_read(19'h2A5C3, 0, nv, ne);
        chk(nv == 1 && ne == 0, "R3 ready now", nv * 16 + ne, 16);
        run_read(19'h3FFFF, 7, nv, ne);
        chk(nv == 1 && ne == 0, "R3 ready late", nv * 16 + ne, 16);
        run_read(19'h15555, 3, nv, ne);
        chk(nv == 1 && result === 19'h15555, "R5 alternating", 32'(result), 32'h15555);

        // R7: boundary of the poll limit
        run_read(19'h00000, LIM - 1, nv, ne);
        chk(nv == 1 && ne == 0, "R7 last poll", nv * 16 + ne, 16);
        run_read(19'h0F0F0, LIM, nv, ne);
        chk(nv == 0 && ne == 1, "R7 timeout", nv * 16 + ne, 1);
        chk(result === 19'h00000, "R10 hold after timeout", 32'(result), 0);

        // R9: start during clocking is ignored
        v0 = vld_cnt;
        cv_word = 19'h33CC3; cv_busy = 2;
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        repeat (20) @(posedge clk);
        #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        repeat (200) @(posedge clk);
        chk(vld_cnt - v0 == 1, "R9 one word", vld_cnt - v0, 1);
        chk(cs_n === 1'b1, "R9 idle after", 32'(cs_n), 1);

        // R8: single start does nothing more
        v0 = vld_cnt;
        repeat (60) @(posedge clk);
        chk(vld_cnt == v0 && cs_n === 1'b1, "R8 no repeat", vld_cnt - v0, 0);

        // R8: continuous reads
        v0 = vld_cnt;
        cv_word = 19'h1B2D4; cv_busy = 4;
        @(posedge clk); #2 cont = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            if (vld_cnt - v0 >= 3) break;
        end
        #2 cont = 1'b0;
        repeat (300) @(posedge clk);
        chk(vld_cnt - v0 == 4, "R8 continuous", vld_cnt - v0, 4);
        chk(err_cnt == 1, "R7 error total", err_cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule